// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts hardware events for a processor core. It holds two 32-bit counters, packed side by side in one 64-bit counter register, and one 64-bit control register that picks, for each counter, which line of an incoming event vector it counts. Counting is allowed or blocked by three context-enable bits (user, supervisor, hypervisor) that both counters share. A current-privilege input selects which of the three applies in each cycle. When every enable is clear, both counters stop together, and neither can be stopped alone.

To keep one counter idle while the other runs, software gives the idle counter a reserved "park" event code that never counts. A counter that steps from all ones to zero sets a sticky overflow flag for that counter. The interrupt output is raised while any flag is set and the interrupt-enable bit is on. Software can load a counter with the negated sample period so that it wraps after exactly that many events. Software reaches the control, counter and status registers over a simple register bus. Writes are single-cycle and reads are combinational.

Top module: `pmu_dual_counter`

## Requirements
- R1: After reset the control register, both counters and both overflow flags are zero, and `ovf_irq` is low.
- R2: Register map on `reg_addr`: 0 is control (only its defined bits are stored; all other bits read as zero); 1 is the counter pair (upper counter in bits 63:32, lower in 31:0), and a write loads both halves; 2 is status (bit 0 is the lower flag, bit 1 the upper flag); 3 reads as zero.
- R3: The lower counter's 6-bit event code sits in control bits 9:4 and the upper counter's in bits 16:11. Code n counts one per clock cycle in which `event_in[n]` is high. A code of `NUM_EVENTS` or above counts nothing.
- R4: Control bit 1 enables counting in supervisor, bit 2 in user and bit 3 in hypervisor. `priv_lvl` encodes 0 user, 1 supervisor, 2 hypervisor and 3 none, and 3 never counts. With bits 3:1 all clear, both counters hold.
- R5: The park codes 0x14 in the lower field and 0x1C in the upper field count nothing, even when they name an active event line. Each park code counts normally in the other field.
- R6: A counter that steps from 0xFFFFFFFF to 0 sets its sticky flag and keeps counting from 0.
- R7: `ovf_irq` is high exactly while control bit 0 is set and at least one flag is set. Clearing bit 0 drops the interrupt but keeps the flags.
- R8: Writing a one to a status bit clears that flag. A wrap in the same cycle as the clear leaves the flag set.
- R9: A counter-register write in the same cycle as an event loads the written value, with no increment and no flag.
- R10: A control write takes effect at its clock edge. Counting in the cycle of the write still uses the previous control value.
- R11: A counter loaded with the two's complement of N wraps on exactly the Nth counted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| event_in | input | NUM_EVENTS | Event lines, one count per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A software write and a hardware event can arrive on the same edge in three forms. A counter load can meet an increment, a status clear can meet a wrap, and a control change can meet a counted event. The bench provokes each form by raising the selected event line during the write cycle. It then reads back the counters, the status bits and the interrupt. The reference model follows the stated priority in each case: the load wins over the increment, the set wins over the clear, and the old control value governs the count.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int ADDR_W    = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam int IE_BIT  = 0;
    localparam int SUP_BIT = 1;
    localparam int USR_BIT = 2;
    localparam int HYP_BIT = 3;
    localparam int CTX_W   = 4;

    localparam int NUM_LANES = 2;
    localparam int LANE_LO   = 0;
    localparam int LANE_HI   = 1;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_SUP  = 2'b01,
        PRIV_HYP  = 2'b10,
        PRIV_NONE = 2'b11
    } priv_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pmu_ctx_gate.sv
`timescale 1ns/1ps
module pmu_ctx_gate
    import pmu_pkg::*;
(
    input  logic [1:0] priv_lvl,
    input  logic       en_user,
    input  logic       en_sup,
    input  logic       en_hyp,
    output logic       ctx_ok
);
    priv_e cur_priv;
    assign cur_priv = priv_e'(priv_lvl);

    always_comb begin
        unique case (cur_priv)
            PRIV_USER: ctx_ok = en_user;
            PRIV_SUP:  ctx_ok = en_sup;
            PRIV_HYP:  ctx_ok = en_hyp;
            PRIV_NONE: ctx_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_event_sel.sv
`timescale 1ns/1ps
module pmu_event_sel #(
    parameter int               NUM_EVENTS = 16,
    parameter int               SEL_W      = 6,
    parameter logic [SEL_W-1:0] PARK_CODE  = '0
) (
    input  logic [SEL_W-1:0]      code,
    input  logic [NUM_EVENTS-1:0] event_in,
    output logic                  hit
);
    localparam int CODE_SPAN = 1 << SEL_W;
    localparam int SPAN = (NUM_EVENTS < CODE_SPAN) ? NUM_EVENTS : CODE_SPAN;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < SPAN; k++) begin
            if (code == SEL_W'(k)) begin
                hit = event_in[k];
            end
        end
        if (code == PARK_CODE) begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
module pmu_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    logic at_top;
    assign at_top = &cnt_q;
    assign wrap   = inc & ~load & at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmu_flag.sv
`timescale 1ns/1ps
module pmu_flag
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set)         state_d = FLAG_SET;
            FLAG_SET:   if (clr && !set) state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/pmu_dual_counter.sv
`timescale 1ns/1ps
module pmu_dual_counter
    import pmu_pkg::*;
#(
    parameter int               NUM_EVENTS = 16,
    parameter int               CNT_W      = 32,
    parameter int               SEL_W      = 6,
    parameter int               LO_SHIFT   = 4,
    parameter int               HI_SHIFT   = 11,
    parameter logic [SEL_W-1:0] LO_PARK    = 6'h14,
    parameter logic [SEL_W-1:0] HI_PARK    = 6'h1C
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            priv_lvl,
    input  logic [NUM_EVENTS-1:0] event_in,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [2*CNT_W-1:0]    reg_wdata,
    output logic [2*CNT_W-1:0]    reg_rdata,
    output logic                  ovf_irq
);
    localparam int REG_W = NUM_LANES * CNT_W;
    localparam logic [REG_W-1:0] SEL_ONES = {{(REG_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};
    localparam logic [REG_W-1:0] CTX_ONES = {{(REG_W-CTX_W){1'b0}}, {CTX_W{1'b1}}};
    localparam logic [REG_W-1:0] CTRL_MASK =
        (SEL_ONES << LO_SHIFT) | (SEL_ONES << HI_SHIFT) | CTX_ONES;

    logic [REG_W-1:0]     ctrl_q;
    logic                 wr_ctrl, wr_cnt, wr_stat;
    logic                 ctx_ok;
    logic [NUM_LANES-1:0] lane_hit, lane_wrap, lane_flag;
    logic [REG_W-1:0]     cnt_packed;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_cnt  = reg_wr && (reg_addr == ADDR_CNT);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= reg_wdata & CTRL_MASK;
        end
    end

    pmu_ctx_gate u_ctx (
        .priv_lvl (priv_lvl),
        .en_user  (ctrl_q[USR_BIT]),
        .en_sup   (ctrl_q[SUP_BIT]),
        .en_hyp   (ctrl_q[HYP_BIT]),
        .ctx_ok   (ctx_ok)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int SHIFT = (i == LANE_HI) ? HI_SHIFT : LO_SHIFT;
        localparam logic [SEL_W-1:0] PARK = (i == LANE_HI) ? HI_PARK : LO_PARK;

        logic [SEL_W-1:0] code;
        logic [CNT_W-1:0] cnt;
        assign code = ctrl_q[SHIFT +: SEL_W];

        pmu_event_sel #(
            .NUM_EVENTS (NUM_EVENTS),
            .SEL_W      (SEL_W),
            .PARK_CODE  (PARK)
        ) u_sel (
            .code     (code),
            .event_in (event_in),
            .hit      (lane_hit[i])
        );

        pmu_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_cnt),
            .load_val (reg_wdata[i*CNT_W +: CNT_W]),
            .inc      (lane_hit[i] & ctx_ok),
            .cnt_q    (cnt),
            .wrap     (lane_wrap[i])
        );

        pmu_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (lane_wrap[i]),
            .clr   (wr_stat & reg_wdata[i]),
            .flag  (lane_flag[i])
        );

        assign cnt_packed[i*CNT_W +: CNT_W] = cnt;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_CNT:  reg_rdata = cnt_packed;
            ADDR_STAT: reg_rdata = {{(REG_W-NUM_LANES){1'b0}}, lane_flag};
            default:   reg_rdata = '0;
        endcase
    end

    assign ovf_irq = ctrl_q[IE_BIT] & (|lane_flag);
endmodule

// File: rtl/pmu_dual_counter_chk.sv
`timescale 1ns/1ps
module pmu_dual_counter_chk
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           priv_lvl,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [2*CNT_W-1:0]   reg_wdata,
    input logic                 ovf_irq,
    input logic [CTX_W-1:0]     ctx_bits,
    input logic [2*CNT_W-1:0]   cnt_packed,
    input logic [NUM_LANES-1:0] lane_flag
);
    logic [CNT_W-1:0] cnt_lo;
    logic             cnt_wr, any_flag;
    assign cnt_lo   = cnt_packed[CNT_W-1:0];
    assign cnt_wr   = reg_wr && (reg_addr == ADDR_CNT);
    assign any_flag = |lane_flag;

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (cnt_packed == '0 && lane_flag == '0)); // R1
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) cnt_wr |=> cnt_packed == $past(reg_wdata)); // R9
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) !cnt_wr |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 1'b1)); // R3
    AST_ALL_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ctx_bits[3:1] == 3'b000 && !cnt_wr) |=> $stable(cnt_packed)); // R4
    AST_NO_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n) (priv_lvl == 2'b11 && !cnt_wr) |=> $stable(cnt_packed)); // R4
    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(lane_flag[0]) |-> ($past(cnt_lo) == '1 && cnt_lo == '0)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (lane_flag[0] && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[0])) |=> lane_flag[0]); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_irq) |-> ($rose(any_flag) || $rose(ctx_bits[IE_BIT]))); // R7
endmodule

bind pmu_dual_counter pmu_dual_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_lvl   (priv_lvl),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ovf_irq    (ovf_irq),
    .ctx_bits   (ctrl_q[CTX_W-1:0]),
    .cnt_packed (cnt_packed),
    .lane_flag  (lane_flag)
);

// File: tb/sim_pmu_dual_counter.sv
`timescale 1ns/1ps
module sim_pmu_dual_counter;
    localparam int NEV = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     priv_lvl;
    logic [NEV-1:0] event_in;
    logic           reg_wr;
    logic [1:0]     reg_addr;
    logic [63:0]    reg_wdata;
    logic [63:0]    reg_rdata;
    logic           ovf_irq;

    int    n_checks = 0;
    int    n_err    = 0;
    bit    done     = 1'b0;
    string phase    = "R1";

    always #10 clk = ~clk;

    pmu_dual_counter #(.NUM_EVENTS(NEV)) u0 (
        .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .event_in(event_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_irq(ovf_irq)
    );

    // Behavioural reference model
    logic [63:0] m_ctrl;
    logic [31:0] m_cnt [2];
    logic [1:0]  m_fl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt[0] = '0; m_cnt[1] = '0; m_fl = '0;
        end else begin
            bit       en;
            logic [1:0] wraps, clr;
            wraps = 2'b00;
            case (priv_lvl)
                2'd0:    en = m_ctrl[2];
                2'd1:    en = m_ctrl[1];
                2'd2:    en = m_ctrl[3];
                default: en = 1'b0;
            endcase
            for (int ln = 0; ln < 2; ln++) begin
                int code, park;
                bit hit;
                code = (ln == 1) ? int'(m_ctrl[16:11]) : int'(m_ctrl[9:4]);
                park = (ln == 1) ? 28 : 20;
                hit  = 1'b0;
                if (en && code != park && code < NEV) hit = event_in[code];
                if (reg_wr && reg_addr == 2'd1) begin
                    m_cnt[ln] = reg_wdata[ln*32 +: 32];
                end else if (hit) begin
                    if (m_cnt[ln] == 32'hFFFF_FFFF) wraps[ln] = 1'b1;
                    m_cnt[ln] = m_cnt[ln] + 32'd1;
                end
            end
            clr  = (reg_wr && reg_addr == 2'd2) ? reg_wdata[1:0] : 2'b00;
            m_fl = (m_fl & ~clr) | wraps;
            if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata & 64'h1FBFF;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Compare against the model on every clock, away from the edges
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic [63:0] exp;
            case (reg_addr)
                2'd0:    exp = m_ctrl;
                2'd1:    exp = {m_cnt[1], m_cnt[0]};
                2'd2:    exp = {62'd0, m_fl};
                default: exp = '0;
            endcase
            check(phase, reg_rdata, exp);
            check(phase, {63'd0, ovf_irq}, {63'd0, m_ctrl[0] & (|m_fl)});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_ev(input logic [1:0] a, input logic [63:0] d, input logic [NEV-1:0] ev);
        event_in = ev;
        wr(a, d);
        event_in = '0;
    endtask

    task automatic run(input int n, input logic [NEV-1:0] ev);
        event_in = ev;
        repeat (n) @(negedge clk);
        event_in = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL %s got=timeout exp=completion", phase);
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst_n = 1'b0; priv_lvl = 2'd0; event_in = '0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        phase = "R1";
        rd(2'd0, v); check("R1 ctrl", v, 64'd0);
        rd(2'd1, v); check("R1 cnt", v, 64'd0);
        rd(2'd2, v); check("R1 stat", v, 64'd0);
        check("R1 irq", {63'd0, ovf_irq}, 64'd0);

        // R2: register map
        phase = "R2";
        wr(2'd1, 64'h1234_5678_9ABC_DEF0);
        rd(2'd1, v); check("R2 cnt pack", v, 64'h1234_5678_9ABC_DEF0);
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); check("R2 ctrl mask", v, 64'h1FBFF);
        wr(2'd0, 64'd0);
        rd(2'd3, v); check("R2 spare addr", v, 64'd0);
        wr(2'd1, 64'd0);

        // R3: event selection
        phase = "R3";
        wr(2'd0, (64'd5 << 11) | (64'd3 << 4) | 64'h4);
        run(4, 32'h8);
        run(2, 32'h20);
        run(3, 32'h28);
        rd(2'd1, v); check("R3 select", v, {32'd5, 32'd7});
        wr(2'd0, (64'd45 << 11) | (64'd40 << 4) | 64'h4);
        run(3, '1);
        rd(2'd1, v); check("R3 code out of range", v, {32'd5, 32'd7});

        // R4: context gating
        phase = "R4";
        wr(2'd1, 64'd0);
        wr(2'd0, 64'h1834);
        priv_lvl = 2'd1; run(2, 32'h8);
        priv_lvl = 2'd3; run(2, 32'h8);
        priv_lvl = 2'd2; run(2, 32'h8);
        rd(2'd1, v); check("R4 wrong context", v, 64'd0);
        wr(2'd0, 64'h1836);
        priv_lvl = 2'd1; run(3, 32'h8);
        rd(2'd1, v); check("R4 supervisor", v, {32'd3, 32'd3});
        wr(2'd0, 64'h1838);
        priv_lvl = 2'd2; run(2, 32'h8);
        rd(2'd1, v); check("R4 hypervisor", v, {32'd5, 32'd5});
        wr(2'd0, 64'h1830);
        priv_lvl = 2'd0; run(4, 32'h8);
        rd(2'd1, v); check("R4 all clear", v, {32'd5, 32'd5});

        // R5: park codes
        phase = "R5";
        wr(2'd1, 64'd0);
        wr(2'd0, 64'hE144);
        run(4, '1);
        rd(2'd1, v); check("R5 parked", v, 64'd0);
        wr(2'd0, 64'hA1C4);
        run(2, '1);
        rd(2'd1, v); check("R5 swapped codes count", v, {32'd2, 32'd2});

        // R6 / R11: preload, wrap, continue
        phase = "R6";
        wr(2'd1, {32'hFFFF_FFFE, 32'hFFFF_FFFD});
        wr(2'd0, 64'h1014);
        run(2, 32'h6);
        rd(2'd2, v); check("R11 upper wraps after 2", v, 64'd2);
        check("R7 irq masked", {63'd0, ovf_irq}, 64'd0);
        run(1, 32'h6);
        rd(2'd2, v); check("R11 lower wraps after 3", v, 64'd3);
        run(1, 32'h2);
        rd(2'd1, v); check("R6 continue after wrap", v, {32'd1, 32'd1});

        // R7: interrupt enable
        phase = "R7";
        wr(2'd0, 64'h1015);
        check("R7 irq on", {63'd0, ovf_irq}, 64'd1);
        wr(2'd0, 64'h1014);
        check("R7 irq off", {63'd0, ovf_irq}, 64'd0);
        rd(2'd2, v); check("R7 flags kept", v, 64'd3);

        // R8: write-one-to-clear, set wins
        phase = "R8";
        wr(2'd2, 64'd1);
        rd(2'd2, v); check("R8 clear lower", v, 64'd2);
        wr(2'd1, {32'd1, 32'hFFFF_FFFF});
        wr_ev(2'd2, 64'd1, 32'h2);
        rd(2'd2, v); check("R8 set beats clear", v, 64'd3);
        wr(2'd2, 64'd3);
        rd(2'd2, v); check("R8 clear both", v, 64'd0);

        // R9: counter write beats increment
        phase = "R9";
        wr(2'd1, {32'd0, 32'hFFFF_FFFF});
        wr_ev(2'd1, {32'd7, 32'hFFFF_FFFF}, 32'h6);
        rd(2'd1, v); check("R9 load wins", v, {32'd7, 32'hFFFF_FFFF});
        rd(2'd2, v); check("R9 no flag", v, 64'd0);

        // R10: control write timing
        phase = "R10";
        wr_ev(2'd0, 64'd0, 32'h6);
        rd(2'd1, v); check("R10 old ctrl counts", v, {32'd8, 32'd0});
        rd(2'd2, v); check("R10 wrap under old ctrl", v, 64'd1);
        run(2, 32'h6);
        rd(2'd1, v); check("R10 new ctrl holds", v, {32'd8, 32'd0});

        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule